// File: doc/BRIEF.md
# Read Reply Transmitter with Bus Turnaround

This block is the responding side of a read on a half-duplex, shared, single-wire control line. When the request decoder reports that a read addressed to this device has just finished (the stop bit of the last address character has ended), it pulses `start_i`. That rising edge is edge 0 of a fixed 65-cycle schedule. The block first stops the local receiver from listening. Two turnaround gaps surround the reply, so the bus master and this device never drive the line at the same time. Within the schedule the block enables its driver, holds the line idle, and sends three characters back to back. The receiver is re-armed at the end.

The reply is the device's own identifier followed by the 16-bit register value, low byte first. Each character is one start bit (0), eight data bits sent least significant first, and one stop bit (1). The line output carries two half-cycle values per clock. With Manchester coding on, only the eight data bits of each character become bi-phase symbols; start, stop and idle stay level across the whole cycle. The enable, data and identifier are captured at edge 0 and held for the whole schedule.

Top module: `rd_reply_tx`

## Requirements
- R1: `rx_en_o` is 0 from edge 0 through the cycle before edge 60 and is 1 from edge 60 onwards and whenever no schedule runs. Edge k is the k-th rising edge after the edge that accepted `start_i`; values are observed after that edge.
- R2: `oe_o` is 1 after edges 7 through 54 of a schedule and 0 otherwise, so the driver is released at edge 55.
- R3: `line_o` is 2'b11 (idle) in every cycle outside the reply window, which covers edges 15 to 44, and whenever `oe_o` is 0.
- R4: In the reply window, the 30 cycles after edges 15..44 carry three 10-bit characters with no gap: identifier byte {1'b0, chip_id_i}, then rd_data_i[7:0], then rd_data_i[15:8]. Each character is start 0, data bit 0 first through bit 7, then stop 1. Start is sent as 2'b00 and stop as 2'b11 in both coding modes.
- R5: With Manchester coding captured as 1, each data bit b is sent as `line_o` = {~b, b}. Bit 1 of `line_o` is the first half of the cycle.
- R6: With Manchester coding captured as 0, each data bit b is sent as {b, b}.
- R7: `manch_en_i`, `rd_data_i` and `chip_id_i` are sampled only on the edge that accepts `start_i`; changes during a schedule do not alter the reply.
- R8: A `start_i` high at edges 1 to 64 of a running schedule is ignored. A `start_i` at edge 65 is accepted and becomes edge 0 of a new schedule.
- R9: After reset `oe_o` is 0, `line_o` is 2'b11 and `rx_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control line clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Read request for this device just completed (edge 0) |
| rd_data_i | input | 16 | Register value to return |
| chip_id_i | input | 7 | Own device identifier, returned as acknowledge |
| manch_en_i | input | 1 | 1 = bi-phase code the data bits of the reply |
| line_o | output | 2 | Line value: bit 1 first half-cycle, bit 0 second half |
| oe_o | output | 1 | Line driver enable |
| rx_en_o | output | 1 | Receiver sampling allowed |

## Verification
The assertions guard the cycle-level handshake between the three outputs on every cycle. The receiver must go deaf on the cycle after an accepted strobe. The line must be idle whenever the driver is off. The driver must already be released when listening resumes. A strobe during a schedule must not disturb its count, and the captured coding mode must not change mid-schedule. The exact cycle numbers of each phase, the bit order and value of every reply character in both coding modes, the capture of inputs at edge 0 and the restart exactly at edge 65 are shown only by the bench's scenarios, which compare every output in every cycle against an independent model of the schedule.

// File: rtl/rd_reply_tx.sv
module rd_reply_tx #(
  parameter int CHAR_W = 8,
  parameter int ID_W   = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [2*CHAR_W-1:0]   rd_data_i,
  input  logic [ID_W-1:0]       chip_id_i,
  input  logic                  manch_en_i,
  output logic [1:0]            line_o,
  output logic                  oe_o,
  output logic                  rx_en_o
);

  localparam int SYM_W   = CHAR_W + 2;
  localparam int N_CHARS = 3;
  localparam int FRAME_W = N_CHARS * SYM_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int CNT_W   = 7;

  localparam logic [CNT_W-1:0] E_OE_ON  = CNT_W'(7);
  localparam logic [CNT_W-1:0] E_TX     = CNT_W'(15);
  localparam logic [CNT_W-1:0] E_TX_END = CNT_W'(15 + FRAME_W);
  localparam logic [CNT_W-1:0] E_OE_OFF = CNT_W'(55);
  localparam logic [CNT_W-1:0] E_RX_ON  = CNT_W'(60);
  localparam logic [CNT_W-1:0] E_LAST   = CNT_W'(64);

  function automatic logic [FRAME_W-1:0] payload_mask();
    logic [FRAME_W-1:0] m;
    m = '0;
    for (int c = 0; c < N_CHARS; c++)
      for (int p = 1; p <= CHAR_W; p++)
        m[c*SYM_W + p] = 1'b1;
    return m;
  endfunction

  localparam logic [FRAME_W-1:0] PAY_MASK = payload_mask();

  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] frm_q, frm_d;
  logic               man_q;
  logic               accept;
  logic               in_tx;
  logic [IDX_W-1:0]   idx;
  logic               bit_v;
  logic               is_pay;

  assign accept = start_i && (!busy || cnt == E_LAST);

  for (genvar c = 0; c < N_CHARS; c++) begin : g_char
    if (c == 0) begin : g_id
      assign frm_d[c*SYM_W +: SYM_W] = {1'b1, CHAR_W'(chip_id_i), 1'b0};
    end else begin : g_data
      assign frm_d[c*SYM_W +: SYM_W] = {1'b1, rd_data_i[(c-1)*CHAR_W +: CHAR_W], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      frm_q <= '1;
      man_q <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      frm_q <= frm_d;
      man_q <= manch_en_i;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == E_LAST) busy <= 1'b0;
    end
  end

  assign in_tx   = busy && cnt >= E_TX && cnt < E_TX_END;
  assign idx     = IDX_W'(cnt - E_TX);
  assign bit_v   = in_tx ? frm_q[idx] : 1'b1;
  assign is_pay  = in_tx && PAY_MASK[idx];
  assign line_o  = (man_q && is_pay) ? {~bit_v, bit_v} : {bit_v, bit_v};
  assign oe_o    = busy && cnt >= E_OE_ON && cnt < E_OE_OFF;
  assign rx_en_o = !(busy && cnt < E_RX_ON);

  AST_RX_OFF_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> !rx_en_o); // R1

  AST_IDLE_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> line_o == 2'b11); // R3

  AST_RELEASED_BEFORE_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en_o) |-> !oe_o); // R2

  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && cnt != E_LAST) |=> cnt == $past(cnt) + 1'b1); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(man_q)); // R7

endmodule

// File: tb/rd_reply_tx_tb.sv
`timescale 1ns/1ps
module rd_reply_tx_tb;

  typedef struct {
    logic       oe;
    logic       rx;
    logic [1:0] ln;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic [6:0]  chip_id_i = '0;
  logic        manch_en_i = 1'b1;
  logic [1:0]  line_o;
  logic        oe_o;
  logic        rx_en_o;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    go = 1'b0;
  bit    done = 1'b0;
  string scen = "idle";
  exp_t  q[$];

  always #2.5 clk = ~clk;

  rd_reply_tx u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_data_i(rd_data_i),
    .chip_id_i(chip_id_i), .manch_en_i(manch_en_i),
    .line_o(line_o), .oe_o(oe_o), .rx_en_o(rx_en_o)
  );

  function automatic exp_t model(int k, logic [15:0] d, logic [6:0] id, logic man);
    exp_t e;
    logic [7:0] by;
    logic v;
    int b, c, p;
    e.rx  = (k >= 60);
    e.oe  = (k >= 7 && k < 55);
    e.ln  = 2'b11;
    e.tag = "R3";
    if (k >= 15 && k < 45) begin
      b = k - 15; c = b / 10; p = b % 10;
      by = (c == 0) ? {1'b0, id} : (c == 1) ? d[7:0] : d[15:8];
      if (p == 0) begin
        e.ln = 2'b00; e.tag = "R4";
      end else if (p == 9) begin
        e.ln = 2'b11; e.tag = "R4";
      end else begin
        v = by[p-1];
        e.ln  = man ? {~v, v} : {v, v};
        e.tag = man ? "R4/R5" : "R4/R6";
      end
    end
    return e;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, scen, $time, act, exp);
    end
  endtask

  task automatic launch(logic [15:0] d, logic [6:0] id, logic man, bit replace);
    if (replace && q.size() > 0) void'(q.pop_back());
    rd_data_i  = d;
    chip_id_i  = id;
    manch_en_i = man;
    start_i    = 1'b1;
    for (int k = 0; k <= 65; k++) q.push_back(model(k, d, id, man));
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (go) begin
        if (q.size() > 0) e = q.pop_front();
        else e = model(70, 16'h0, 7'h0, 1'b0);
        check({"R2 oe ", e.tag}, {1'b0, oe_o}, {1'b0, e.oe});
        check({"R1 rx_en ", e.tag}, {1'b0, rx_en_o}, {1'b0, e.rx});
        check({e.tag, " line"}, line_o, e.ln);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    scen = "R9 reset";
    #1;
    check("R9 oe", {1'b0, oe_o}, 2'b00);
    check("R9 line", line_o, 2'b11);
    check("R9 rx_en", {1'b0, rx_en_o}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    go = 1'b1;
    repeat (3) @(negedge clk);

    scen = "R5 manchester";
    launch(16'hA55A, 7'h15, 1'b1, 1'b0);
    repeat (70) @(negedge clk);

    scen = "R6 plain";
    launch(16'h1234, 7'h7F, 1'b0, 1'b0);
    repeat (70) @(negedge clk);

    scen = "R4 zeros";
    launch(16'h0000, 7'h00, 1'b1, 1'b0);
    repeat (68) @(negedge clk);
    scen = "R4 ones";
    launch(16'hFFFF, 7'h7F, 1'b1, 1'b0);
    repeat (70) @(negedge clk);

    scen = "R7 inputs change mid-schedule";
    launch(16'hC3E1, 7'h2A, 1'b1, 1'b0);
    rd_data_i  = 16'h0F0F;
    chip_id_i  = 7'h01;
    manch_en_i = 1'b0;
    repeat (70) @(negedge clk);

    scen = "R8 strobes during schedule";
    launch(16'h5A3C, 7'h09, 1'b0, 1'b0);
    repeat (29) @(negedge clk);
    rd_data_i = 16'hFFFF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (33) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    scen = "R8 restart at edge 65";
    launch(16'h8421, 7'h33, 1'b1, 1'b1);
    repeat (72) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule